// File: doc/BRIEF.md
# Calendar Counter with Tick Wake and Shutdown Control

This block keeps wall-clock time in six binary counters (seconds, minutes, hours, day, month and a year offset from 2000). A fractional prescaler counts enable strobes on `presc_en` and advances the seconds once every `PRESC_DIV` strobes. Software reaches the counters and the control fields through a byte register file. The register pointer is loaded once and then steps by one after every read or write, so the whole time can be moved in one burst. A stored validity flag beside the year shows whether software has ever set the time.

A periodic tick, either once per second or once per minute, can latch an event flag and pulse a wake output. A shutdown command pulses a power-down output and enters an off state. Any tick wake, or a software wake command, leaves that off state again. The usual way to restart a system is to arm the one-second tick wake, issue the shutdown, and let the next tick bring the system back.

Top module: `caltick_rtc`

## Requirements
- R1: After reset the counters read seconds 0, minutes 0, hours 0, day 1, month 1 and year byte 0x00. The event register (0x06) reads 0, `off_state` is 0, and the pulse outputs are low.
- R2: The counters occupy byte addresses 0x40 to 0x45 in the order seconds, minutes, hours, day, month, year. A write or read at the pointer moves the pointer to the next address, so one burst from 0x40 writes or reads all six fields.
- R3: In the year byte, bits 5:0 hold the year offset and bit 6 is a stored validity flag. Bit 6 reads back as written and keeps its value while the year counts.
- R4: Rollover follows this chain. Seconds go 59 to 0 and minutes go 59 to 0, each carrying into the next field. Hours go 23 to 0 and carry into the day. The day goes 31 to 1 and carries into the month. The month goes 12 to 1 and carries into the year. The year offset wraps modulo 64.
- R5: Seconds advance on the `PRESC_DIV`-th `presc_en` strobe counted from reset or from the last write. A write to any counter register clears the prescaler, and no advance happens in the cycle of that write.
- R6: Register 0x4A holds two fields: bit 5 enables tick wake, and bit 4 selects the tick type (0 = one-second tick, 1 = one-minute tick). Bit 7 of register 0x4B switches the tick on. All three bits read back as written, and the other bits of both registers read 0.
- R7: While the tick is on, every tick sets bit 0 of the event register 0x06. Writing a 1 to that bit clears it, and writing a 0 has no effect.
- R8: A tick with both the tick and tick wake enabled gives a one-cycle pulse on `wake_pulse`. This also happens while `off_state` is 1, and the pulse clears `off_state`.
- R9: With tick type 1, a tick happens only on the advance that takes the seconds from 59 to 0.
- R10: With the tick off, no event is set and no wake pulse is produced, but the counters keep counting.
- R11: When a tick and a clearing write to 0x06 fall in the same cycle, the event bit ends up set.
- R12: A write to control register 0x13 with bit 1 set gives a one-cycle `pwrdn_pulse` and sets `off_state`. Writing bit 2 clears `off_state` without a wake pulse. If both bits are written together, the shutdown wins. Bit 1 of 0x13 reads back `off_state`.
- R13: A read of an unmapped address returns 0, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_en | input | 1 | Prescaler advance strobe |
| ptr_load | input | 1 | Load the register pointer from `ptr_val` |
| ptr_val | input | 8 | New pointer address |
| wr_stb | input | 1 | Write `wr_byte` at the pointer, then step the pointer |
| wr_byte | input | 8 | Write data |
| rd_stb | input | 1 | Read at the pointer into `rd_byte`, then step the pointer |
| rd_byte | output | 8 | Data from the last read, valid from the following cycle |
| wake_pulse | output | 1 | One-cycle wake request |
| pwrdn_pulse | output | 1 | One-cycle power-down request |
| off_state | output | 1 | High between a shutdown and the next wake |

## Verification
Two functions can act on the event bit in the same cycle: the tick sets it, and a write-one clear to 0x06 clears it. The bench points the register pointer at 0x06 and counts three prescaler strobes. It then drives the fourth strobe in the same cycle as a clearing write. A readback of 1 confirms that the set wins, and a later clear on its own must return the bit to 0. A second collision is the shutdown and software wake bits written together, which must leave the off state set.

// File: rtl/caltick_pkg.sv
package caltick_pkg;

    localparam int DW   = 8;
    localparam int NCNT = 6;

    localparam logic [7:0] A_EVT    = 8'h06;
    localparam logic [7:0] A_CTL    = 8'h13;
    localparam logic [7:0] A_CNT0   = 8'h40;
    localparam logic [7:0] A_ALM_MO = 8'h4A;
    localparam logic [7:0] A_ALM_YR = 8'h4B;

    localparam int B_WAKE_EN = 5;
    localparam int B_TYPE    = 4;
    localparam int B_TICK_ON = 7;
    localparam int B_SHDN    = 1;
    localparam int B_SWAKE   = 2;
    localparam int B_VALID   = 6;

    typedef enum logic [2:0] {
        F_SEC = 3'd0, F_MIN = 3'd1, F_HR = 3'd2,
        F_DAY = 3'd3, F_MON = 3'd4, F_YR = 3'd5
    } field_e;

    typedef struct packed {
        logic       valid;
        logic [5:0] yr;
        logic [3:0] mon;
        logic [4:0] day;
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sec;
    } cal_t;

    function automatic logic [DW-1:0] field_rd(cal_t c, logic [2:0] f);
        case (field_e'(f))
            F_SEC:   return {2'b00, c.sec};
            F_MIN:   return {2'b00, c.mn};
            F_HR:    return {3'b000, c.hr};
            F_DAY:   return {3'b000, c.day};
            F_MON:   return {4'h0, c.mon};
            F_YR:    return {1'b0, c.valid, c.yr};
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/caltick_presc.sv
module caltick_presc #(
    parameter int PRESC_DIV = 32768,
    localparam int CW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          clr,
    output logic          adv,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(PRESC_DIV - 1);

    assign adv = en && !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en)
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/caltick_count.sv
module caltick_count
    import caltick_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          wr,
    input  logic [2:0]    wsel,
    input  logic [DW-1:0] wdat,
    output cal_t          cal,
    output logic          min_carry
);
    logic c_sec, c_min, c_hr, c_day, c_mon;

    assign c_sec = adv && (cal.sec >= 6'd59);
    assign c_min = c_sec && (cal.mn >= 6'd59);
    assign c_hr  = c_min && (cal.hr >= 5'd23);
    assign c_day = c_hr && (cal.day >= 5'd31);
    assign c_mon = c_day && (cal.mon >= 4'd12);
    assign min_carry = c_sec;

    always_ff @(posedge clk) begin
        if (rst) begin
            cal <= '{valid: 1'b0, yr: 6'd0, mon: 4'd1, day: 5'd1,
                     hr: 5'd0, mn: 6'd0, sec: 6'd0};
        end else if (wr) begin
            case (field_e'(wsel))
                F_SEC: cal.sec <= wdat[5:0];
                F_MIN: cal.mn  <= wdat[5:0];
                F_HR:  cal.hr  <= wdat[4:0];
                F_DAY: cal.day <= wdat[4:0];
                F_MON: cal.mon <= wdat[3:0];
                F_YR: begin
                    cal.yr    <= wdat[5:0];
                    cal.valid <= wdat[B_VALID];
                end
                default: ;
            endcase
        end else if (adv) begin
            cal.sec <= c_sec ? 6'd0 : cal.sec + 6'd1;
            if (c_sec) cal.mn  <= c_min ? 6'd0 : cal.mn + 6'd1;
            if (c_min) cal.hr  <= c_hr ? 5'd0 : cal.hr + 5'd1;
            if (c_hr)  cal.day <= c_day ? 5'd1 : cal.day + 5'd1;
            if (c_day) cal.mon <= c_mon ? 4'd1 : cal.mon + 4'd1;
            if (c_mon) cal.yr  <= cal.yr + 6'd1;
        end
    end
endmodule

// File: rtl/caltick_ctrl.sv
module caltick_ctrl
    import caltick_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sec_tick,
    input  logic          min_tick,
    input  logic          wr_almmo,
    input  logic          wr_almyr,
    input  logic          wr_evt,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdat,
    output logic          wake_en,
    output logic          tick_type,
    output logic          tick_on,
    output logic          evt_q,
    output logic          evt_set,
    output logic          evt_w1c,
    output logic          off_q,
    output logic          wake_o,
    output logic          pwrdn_o
);
    logic shdn_req, swake_req, wake_now;

    assign evt_set   = tick_on && (tick_type ? min_tick : sec_tick);
    assign evt_w1c   = wr_evt && wdat[0];
    assign wake_now  = evt_set && wake_en;
    assign shdn_req  = wr_ctl && wdat[B_SHDN];
    assign swake_req = wr_ctl && wdat[B_SWAKE];

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_en   <= 1'b0;
            tick_type <= 1'b0;
            tick_on   <= 1'b0;
            evt_q     <= 1'b0;
            off_q     <= 1'b0;
            wake_o    <= 1'b0;
            pwrdn_o   <= 1'b0;
        end else begin
            if (wr_almmo) begin
                wake_en   <= wdat[B_WAKE_EN];
                tick_type <= wdat[B_TYPE];
            end
            if (wr_almyr)
                tick_on <= wdat[B_TICK_ON];
            if (evt_set)
                evt_q <= 1'b1;
            else if (evt_w1c)
                evt_q <= 1'b0;
            if (shdn_req)
                off_q <= 1'b1;
            else if (wake_now || swake_req)
                off_q <= 1'b0;
            wake_o  <= wake_now;
            pwrdn_o <= shdn_req;
        end
    end
endmodule

// File: rtl/caltick_rtc.sv
module caltick_rtc
    import caltick_pkg::*;
#(
    parameter int PRESC_DIV = 32768,
    localparam int PCW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          presc_en,
    input  logic          ptr_load,
    input  logic [7:0]    ptr_val,
    input  logic          wr_stb,
    input  logic [DW-1:0] wr_byte,
    input  logic          rd_stb,
    output logic [DW-1:0] rd_byte,
    output logic          wake_pulse,
    output logic          pwrdn_pulse,
    output logic          off_state
);
    logic [7:0]     ptr;
    logic [7:0]     rel;
    logic           in_cnt, cnt_wr, sec_adv, min_carry;
    logic [PCW-1:0] presc_cnt;
    cal_t           cal;
    logic           wake_en, tick_type, tick_on, evt_q, evt_set, evt_w1c;
    logic [DW-1:0]  rd_mux;

    assign rel    = ptr - A_CNT0;
    assign in_cnt = (ptr >= A_CNT0) && (rel < 8'(NCNT));
    assign cnt_wr = wr_stb && in_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (ptr_load)
            ptr <= ptr_val;
        else if (wr_stb || rd_stb)
            ptr <= ptr + 8'd1;
    end

    caltick_presc #(.PRESC_DIV(PRESC_DIV)) u_pre (
        .clk(clk), .rst(rst), .en(presc_en), .clr(cnt_wr),
        .adv(sec_adv), .cnt(presc_cnt)
    );

    caltick_count u_cnt (
        .clk(clk), .rst(rst), .adv(sec_adv), .wr(cnt_wr),
        .wsel(rel[2:0]), .wdat(wr_byte), .cal(cal), .min_carry(min_carry)
    );

    caltick_ctrl u_ctl (
        .clk(clk), .rst(rst), .sec_tick(sec_adv), .min_tick(min_carry),
        .wr_almmo(wr_stb && ptr == A_ALM_MO),
        .wr_almyr(wr_stb && ptr == A_ALM_YR),
        .wr_evt(wr_stb && ptr == A_EVT),
        .wr_ctl(wr_stb && ptr == A_CTL),
        .wdat(wr_byte),
        .wake_en(wake_en), .tick_type(tick_type), .tick_on(tick_on),
        .evt_q(evt_q), .evt_set(evt_set), .evt_w1c(evt_w1c),
        .off_q(off_state), .wake_o(wake_pulse), .pwrdn_o(pwrdn_pulse)
    );

    always_comb begin
        rd_mux = '0;
        if (in_cnt)
            rd_mux = field_rd(cal, rel[2:0]);
        else begin
            case (ptr)
                A_EVT:    rd_mux = {7'b0, evt_q};
                A_CTL:    rd_mux = {6'b0, off_state, 1'b0};
                A_ALM_MO: rd_mux = {2'b00, wake_en, tick_type, 4'h0};
                A_ALM_YR: rd_mux = {tick_on, 7'b0};
                default:  rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_byte <= '0;
        else if (rd_stb)
            rd_byte <= rd_mux;
    end
endmodule

// File: rtl/caltick_rtc_chk.sv
module caltick_rtc_chk #(
    parameter int PCW = 1
) (
    input logic           clk,
    input logic           rst,
    input logic           wake_pulse,
    input logic           pwrdn_pulse,
    input logic           off_state,
    input logic           tick_on,
    input logic           wake_en,
    input logic           cnt_wr,
    input logic [PCW-1:0] presc_cnt,
    input logic           sec_adv,
    input logic [5:0]     sec,
    input logic           evt_q,
    input logic           evt_set,
    input logic           evt_w1c
);
    // R12
    pwrdn_single_chk: assert property (@(posedge clk) disable iff (rst)
        pwrdn_pulse |=> !pwrdn_pulse);

    // R12
    pwrdn_off_chk: assert property (@(posedge clk) disable iff (rst)
        pwrdn_pulse |-> off_state);

    // R8
    wake_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> $past(tick_on && wake_en));

    // R5
    presc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (presc_cnt == '0));

    // R4
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_adv && !cnt_wr && sec < 6'd59) |=> (sec == $past(sec) + 6'd1));

    // R7
    evt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_w1c && !evt_set) |=> !evt_q);

    // R11
    evt_setwins_chk: assert property (@(posedge clk) disable iff (rst)
        evt_set |=> evt_q);
endmodule

bind caltick_rtc caltick_rtc_chk #(.PCW(PCW)) u_chk (
    .clk(clk), .rst(rst), .wake_pulse(wake_pulse), .pwrdn_pulse(pwrdn_pulse),
    .off_state(off_state), .tick_on(tick_on), .wake_en(wake_en),
    .cnt_wr(cnt_wr), .presc_cnt(presc_cnt), .sec_adv(sec_adv),
    .sec(cal.sec), .evt_q(evt_q), .evt_set(evt_set), .evt_w1c(evt_w1c)
);

// File: tb/caltick_rtc_tb_top.sv
`timescale 1ns/1ps
module caltick_rtc_tb_top;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       presc_en = 1'b0;
    logic       ptr_load = 1'b0;
    logic [7:0] ptr_val = '0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_byte;
    logic       wake_pulse, pwrdn_pulse, off_state;

    int n_chk = 0;
    int n_bad = 0;
    int wake_cnt = 0;
    int pwrdn_cnt = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    caltick_rtc #(.PRESC_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .presc_en(presc_en), .ptr_load(ptr_load),
        .ptr_val(ptr_val), .wr_stb(wr_stb), .wr_byte(wr_byte),
        .rd_stb(rd_stb), .rd_byte(rd_byte), .wake_pulse(wake_pulse),
        .pwrdn_pulse(pwrdn_pulse), .off_state(off_state)
    );

    always @(negedge clk) begin
        cyc++;
        if (wake_pulse) wake_cnt++;
        if (pwrdn_pulse) pwrdn_cnt++;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_ptr(input logic [7:0] a);
        @(negedge clk); ptr_load = 1'b1; ptr_val = a;
        @(negedge clk); ptr_load = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_byte = d;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d);
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0; d = rd_byte;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); presc_en = 1'b1;
            @(negedge clk); presc_en = 1'b0;
        end
    endtask

    task automatic wr_at(input logic [7:0] a, input logic [7:0] d);
        set_ptr(a); wr(d);
    endtask

    task automatic rd_at(input logic [7:0] a, output logic [7:0] d);
        set_ptr(a); rd(d);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        int exp[6] = '{0, 0, 0, 1, 1, 0};
        set_ptr(8'h40);
        for (int i = 0; i < 6; i++) begin
            rd(d); chk("R1 counter reset", d, exp[i]);
        end
        rd_at(8'h06, d); chk("R1 event reset", d, 0);
        chk("R1 off reset", off_state, 0);
        chk("R1 pulses reset", wake_cnt + pwrdn_cnt, 0);
    endtask

    task automatic t_burst;
        logic [7:0] d;
        int v[6] = '{12, 34, 5, 6, 7, 8'h55};
        set_ptr(8'h40);
        for (int i = 0; i < 6; i++) wr(8'(v[i]));
        set_ptr(8'h40);
        for (int i = 0; i < 6; i++) begin
            rd(d); chk("R2 burst readback", d, v[i]);
        end
        chk("R3 year valid bit", d[6], 1);
    endtask

    task automatic t_roll;
        logic [7:0] d;
        int v[6] = '{59, 59, 23, 31, 12, 8'h7F};
        int e[6] = '{0, 0, 0, 1, 1, 8'h40};
        set_ptr(8'h40);
        for (int i = 0; i < 6; i++) wr(8'(v[i]));
        pulses(DIV);
        set_ptr(8'h40);
        for (int i = 0; i < 6; i++) begin
            rd(d); chk("R4 rollover chain", d, e[i]);
        end
        chk("R3 valid kept through wrap", d[6], 1);
    endtask

    task automatic t_presc;
        logic [7:0] d;
        wr_at(8'h40, 8'd10);
        pulses(DIV - 1);
        wr_at(8'h40, 8'd10);
        pulses(DIV - 1);
        rd_at(8'h40, d); chk("R5 prescaler cleared by write", d, 10);
        pulses(1);
        rd_at(8'h40, d); chk("R5 advance on last strobe", d, 11);
    endtask

    task automatic t_wake;
        logic [7:0] d;
        int w0, p0;
        set_ptr(8'h4A); wr(8'h20); wr(8'h80);
        rd_at(8'h4A, d); chk("R6 alarm-month readback", d, 8'h20);
        rd(d);           chk("R6 alarm-year readback", d, 8'h80);
        wr_at(8'h06, 8'h01);
        p0 = pwrdn_cnt;
        wr_at(8'h13, 8'h02); idle(2);
        chk("R12 pwrdn one cycle", pwrdn_cnt - p0, 1);
        chk("R12 off set", off_state, 1);
        rd_at(8'h13, d); chk("R12 off readback", d, 8'h02);
        w0 = wake_cnt;
        wr_at(8'h40, 8'd0);
        pulses(DIV); idle(1);
        chk("R8 wake pulse during off", wake_cnt - w0, 1);
        chk("R8 off cleared by wake", off_state, 0);
        rd_at(8'h06, d); chk("R7 event latched", d, 1);
        wr_at(8'h06, 8'h00);
        rd_at(8'h06, d); chk("R7 write zero keeps event", d, 1);
        wr_at(8'h06, 8'h01);
        rd_at(8'h06, d); chk("R7 write one clears event", d, 0);
    endtask

    task automatic t_minute;
        logic [7:0] d;
        int w0;
        wr_at(8'h4A, 8'h30);
        wr_at(8'h06, 8'h01);
        wr_at(8'h41, 8'd3);
        wr_at(8'h40, 8'd58);
        w0 = wake_cnt;
        pulses(DIV); idle(1);
        chk("R9 no tick at 59", wake_cnt - w0, 0);
        pulses(DIV); idle(1);
        chk("R9 tick on minute carry", wake_cnt - w0, 1);
        rd_at(8'h41, d); chk("R9 minute advanced", d, 4);
    endtask

    task automatic t_off;
        logic [7:0] d;
        int w0;
        set_ptr(8'h4A); wr(8'h20); wr(8'h00);
        wr_at(8'h06, 8'h01);
        wr_at(8'h40, 8'd0);
        w0 = wake_cnt;
        pulses(DIV); idle(1);
        chk("R10 no wake with tick off", wake_cnt - w0, 0);
        rd_at(8'h06, d); chk("R10 no event with tick off", d, 0);
        rd_at(8'h40, d); chk("R10 counting continues", d, 1);
    endtask

    task automatic t_collide;
        logic [7:0] d;
        wr_at(8'h4B, 8'h80);
        wr_at(8'h40, 8'd0);
        set_ptr(8'h06);
        pulses(DIV - 1);
        @(negedge clk); presc_en = 1'b1; wr_stb = 1'b1; wr_byte = 8'h01;
        @(negedge clk); presc_en = 1'b0; wr_stb = 1'b0;
        rd_at(8'h06, d); chk("R11 set wins over clear", d, 1);
        wr_at(8'h06, 8'h01);
        rd_at(8'h06, d); chk("R11 later clear alone", d, 0);
        wr_at(8'h4B, 8'h00);
    endtask

    task automatic t_ctl;
        int w0;
        w0 = wake_cnt;
        wr_at(8'h13, 8'h02); idle(1);
        wr_at(8'h13, 8'h04); idle(1);
        chk("R12 software wake clears off", off_state, 0);
        chk("R12 software wake no pulse", wake_cnt - w0, 0);
        wr_at(8'h13, 8'h06); idle(1);
        chk("R12 shutdown wins over wake", off_state, 1);
        wr_at(8'h13, 8'h04);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        wr_at(8'h20, 8'hFF);
        rd_at(8'h20, d); chk("R13 unmapped reads zero", d, 0);
        rd_at(8'h4B, d); chk("R13 neighbours untouched", d, 0);
    endtask

    initial begin : watchdog
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_burst();
        t_roll();
        t_presc();
        t_wake();
        t_minute();
        t_off();
        t_collide();
        t_ctl();
        t_unmapped();
        idle(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule